// File: doc/BRIEF.md
# Luma 4x4 Intra Predictor

This block builds a 4x4 tile of predicted luma samples from the reconstructed samples around it. It uses four samples from the column to the left, eight from the row above (four directly above and four above-right), and the single corner sample above-left. A 4-bit code selects one of nine predictors: two copy modes, a flat mean and six directional modes. The directional modes run 3-tap and 2-tap smoothing filters along the edge and then project the results into the tile along a diagonal.

A 4-bit mask tells the block which neighbours exist. A missing above-right group is replaced internally by repeating the last above sample. A mode that needs a neighbour the mask marks as absent is rejected, and so is a code outside the nine modes. When a request is rejected, the error flag rises and the previous prediction stays on the output.

The block has one capture stage and one result stage. A start strobe latches the inputs. On the next clock the sixteen samples, the error flag and a one-cycle done pulse appear together. The outputs then hold until the next result.

Top module: `intra4x4_pred`

## Requirements
- R1: After reset, `pred_o` is all zero and `done_o` and `err_o` are low.
- R2: Inputs are captured on a rising edge where `start_i` is high. `done_o` goes high after the following rising edge and stays high for exactly one cycle. `pred_o` and `err_o` change only on the edge that raises `done_o`.
- R3: Mode codes are 0 vertical, 1 horizontal, 2 DC, 3 down-left, 4 down-right, 5 vertical-right, 6 horizontal-down, 7 vertical-left and 8 horizontal-up. The mask bits are [0] left, [1] above, [2] above-left and [3] above-right. An error is raised in these cases: the code is 9 to 15; mode 0, 3 or 7 is used without above; mode 1 or 8 is used without left; mode 4, 5 or 6 is used without all of above, left and above-left. DC is never an error. On an error, `pred_o` keeps its previous value.
- R4: The 3-tap filter is (a+2b+c+2)>>2 and the 2-tap filter is (a+b+1)>>1, both computed without overflow. Samples are W bits wide. Left sample k (k=0 at the top) sits in `left_i[k*W +: W]`. Above sample k (k=0 at the left, 4..7 above-right) sits in `above_i[k*W +: W]`. Output sample (x,y) sits in `pred_o[(4*y+x)*W +: W]`.
- R5: Vertical copies above sample x to every row. Horizontal copies left sample y to every column.
- R6: DC fills the tile with a single value. With both left and above available, it is (sum of 8 + 4)>>3. With only one of the two, it is (sum of that 4 + 2)>>2. With neither, it is 2^(W-1).
- R7: Down-left uses t[n] = 3-tap(U[n],U[n+1],U[n+2]) for n=0..5 and t[6] = (U6+3*U7+2)>>2, with output(x,y) = t[x+y]. Without above-right, t[2] = (U2+3*U3+2)>>2 and t[3..6] = U3.
- R8: Down-right applies 3-tap filters along the line L3,L2,L1,L0,UL,U0..U3 to give t[0..6], with output(x,y) = t[3+x-y].
- R9: Vertical-right uses output(x,y) = t[3+2x-y]. Horizontal-down uses output(x,y) = t[3+2y-x]. In both, t[3] is the 2-tap mean of the corner and its first neighbour along the mode's main edge. From t[3] outward, the entries alternate between 3-tap values (centred on the corner, then on each following edge sample) and 2-tap values (on each following pair). The entries below t[3] are 3-tap values going round the corner onto the other edge.
- R10: Vertical-left uses output(x,y) = t[2x+y]. Even entries are 2-tap(U[n],U[n+1]) and odd entries are 3-tap(U[n],U[n+1],U[n+2]), where n = entry index >> 1. Without above-right, t[5] = (U2+3*U3+2)>>2 and t[6..9] = U3.
- R11: Horizontal-up uses output(x,y) = t[x+2y]. Even entries below 5 are 2-tap(L[n],L[n+1]) and odd entries below 5 are 3-tap(L[n],L[n+1],L[n+2]), where n = entry index >> 1. t[5] = (L2+3*L3+2)>>2 and t[6..9] = L3.
- R12: Starts on consecutive cycles each produce their own result, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture strobe |
| left_i | input | 4*W | Left column samples |
| above_i | input | 8*W | Above and above-right samples |
| corner_i | input | W | Above-left sample |
| mode_i | input | 4 | Prediction mode code |
| avail_i | input | 4 | Neighbour availability mask |
| pred_o | output | 16*W | Predicted tile |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Rejected request flag |

## Verification
Each result depends only on the inputs captured one cycle earlier. A wrong filter tap, diagonal index or substitution therefore shows up in particular output pixels on the very done cycle of the mode that uses it, and a sweep over modes, masks and sample patterns isolates which one is wrong. The only state carried between requests is the held prediction after a rejection. A hold defect shows up at the first rejected request, as a changed or zeroed tile. A fault in the capture or strobe timing shows up as a misplaced done pulse, or as a back-to-back pair returning swapped or duplicated tiles.

// File: rtl/intra4_pkg.sv
package intra4_pkg;
  localparam int BLK       = 4;
  localparam int NUM_LEFT  = BLK;
  localparam int NUM_ABOVE = 2 * BLK;
  localparam int NUM_PIX   = BLK * BLK;
  localparam int NUM_MODES = 9;
  localparam int MODE_W    = 4;
  localparam int AVAIL_W   = 4;
  localparam int LINE_LEN  = 15;
  localparam int TAP3_HI   = 13;
  localparam int TAP2_HI   = 10;

  localparam int AV_LEFT   = 0;
  localparam int AV_TOP    = 1;
  localparam int AV_CORNER = 2;
  localparam int AV_TOP_RT = 3;

  typedef enum logic [MODE_W-1:0] {
    M_VERT = 4'd0,
    M_HORZ = 4'd1,
    M_DC   = 4'd2,
    M_DDL  = 4'd3,
    M_DDR  = 4'd4,
    M_VRT  = 4'd5,
    M_HDN  = 4'd6,
    M_VLT  = 4'd7,
    M_HUP  = 4'd8
  } pmode_e;

  // source kinds for the per-pixel selector
  localparam int K_TOP  = 0;
  localparam int K_LEFT = 1;
  localparam int K_T3   = 2;
  localparam int K_T2   = 3;
  localparam int K_DC   = 4;
  localparam int K_SCALE = 16;

  // returns kind*K_SCALE + index for pixel (x,y) in mode m
  function automatic int tap_sel(int m, int x, int y);
    int z;
    case (m)
      0: return K_TOP * K_SCALE + x;
      1: return K_LEFT * K_SCALE + y;
      2: return K_DC * K_SCALE;
      3: return K_T3 * K_SCALE + 7 + x + y;
      4: return K_T3 * K_SCALE + 5 + x - y;
      5: begin
        z = 2 * x - y + 3;
        if (z < 3) return K_T3 * K_SCALE + 3 + z;
        else if ((z % 2) == 1) return K_T2 * K_SCALE + 5 + (z - 3) / 2;
        else return K_T3 * K_SCALE + 6 + (z - 4) / 2;
      end
      6: begin
        z = 2 * y - x + 3;
        if (z < 3) return K_T3 * K_SCALE + 7 - z;
        else if ((z % 2) == 1) return K_T2 * K_SCALE + 4 - (z - 3) / 2;
        else return K_T3 * K_SCALE + 4 - (z - 4) / 2;
      end
      7: begin
        z = 2 * x + y;
        if ((z % 2) == 0) return K_T2 * K_SCALE + 6 + z / 2;
        else return K_T3 * K_SCALE + 7 + (z - 1) / 2;
      end
      default: begin
        z = x + 2 * y;
        if (z >= 6) return K_LEFT * K_SCALE + 3;
        else if ((z % 2) == 0) return K_T2 * K_SCALE + 3 - z / 2;
        else return K_T3 * K_SCALE + 3 - (z - 1) / 2;
      end
    endcase
  endfunction
endpackage

// File: rtl/intra4_edge.sv
module intra4_edge import intra4_pkg::*; #(
  parameter int W = 8
) (
  input  logic [NUM_LEFT-1:0][W-1:0]  left_i,
  input  logic [NUM_ABOVE-1:0][W-1:0] above_i,
  input  logic [W-1:0]                corner_i,
  input  logic                        top_rt_ok_i,
  output logic [TAP3_HI:1][W-1:0]     tap3_o,
  output logic [TAP2_HI:1][W-1:0]     tap2_o
);
  // edge line: L3 L3 L2 L1 L0 UL U0..U7 U7 (ends padded)
  logic [LINE_LEN-1:0][W-1:0] line;

  always_comb begin
    line[0] = left_i[NUM_LEFT-1];
    for (int k = 0; k < NUM_LEFT; k++) line[NUM_LEFT - k] = left_i[k];
    line[NUM_LEFT+1] = corner_i;
    for (int k = 0; k < NUM_ABOVE; k++) begin
      if (k < BLK || top_rt_ok_i) line[NUM_LEFT + 2 + k] = above_i[k];
      else                        line[NUM_LEFT + 2 + k] = above_i[BLK-1];
    end
    line[LINE_LEN-1] = line[LINE_LEN-2];
  end

  for (genvar i = 1; i <= TAP3_HI; i++) begin : g_t3
    assign tap3_o[i] = W'(({2'b00, line[i-1]} + {1'b0, line[i], 1'b0}
                          + {2'b00, line[i+1]} + (W+2)'(2)) >> 2);
  end

  for (genvar i = 1; i <= TAP2_HI; i++) begin : g_t2
    assign tap2_o[i] = W'(({1'b0, line[i]} + {1'b0, line[i+1]} + (W+1)'(1)) >> 1);
  end
endmodule

// File: rtl/intra4_dc.sv
module intra4_dc import intra4_pkg::*; #(
  parameter int W = 8
) (
  input  logic [NUM_LEFT-1:0][W-1:0] left_i,
  input  logic [BLK-1:0][W-1:0]      top_i,
  input  logic                       left_ok_i,
  input  logic                       top_ok_i,
  output logic [W-1:0]               dc_o
);
  localparam int SW = W + 3;
  logic [SW-1:0] sum_l, sum_t;

  always_comb begin
    sum_l = '0;
    sum_t = '0;
    for (int k = 0; k < BLK; k++) begin
      sum_l = sum_l + SW'(left_i[k]);
      sum_t = sum_t + SW'(top_i[k]);
    end
    unique case ({left_ok_i, top_ok_i})
      2'b11:   dc_o = W'((sum_l + sum_t + SW'(4)) >> 3);
      2'b10:   dc_o = W'((sum_l + SW'(2)) >> 2);
      2'b01:   dc_o = W'((sum_t + SW'(2)) >> 2);
      default: dc_o = W'(1) << (W - 1);
    endcase
  end
endmodule

// File: rtl/intra4_legal.sv
module intra4_legal import intra4_pkg::*; (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              left_ok_i,
  input  logic              top_ok_i,
  input  logic              corner_ok_i,
  output logic              bad_o
);
  always_comb begin
    case (mode_i)
      M_VERT, M_DDL, M_VLT: bad_o = !top_ok_i;
      M_HORZ, M_HUP:        bad_o = !left_ok_i;
      M_DC:                 bad_o = 1'b0;
      M_DDR, M_VRT, M_HDN:  bad_o = !(top_ok_i && left_ok_i && corner_ok_i);
      default:              bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/intra4_map.sv
module intra4_map import intra4_pkg::*; #(
  parameter int W = 8
) (
  input  logic [MODE_W-1:0]          mode_i,
  input  logic [NUM_LEFT-1:0][W-1:0] left_i,
  input  logic [BLK-1:0][W-1:0]      top_i,
  input  logic [TAP3_HI:1][W-1:0]    tap3_i,
  input  logic [TAP2_HI:1][W-1:0]    tap2_i,
  input  logic [W-1:0]               dc_i,
  output logic [NUM_PIX-1:0][W-1:0]  pred_o
);
  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    localparam int PX = p % BLK;
    localparam int PY = p / BLK;
    logic [NUM_MODES-1:0][W-1:0] cand;
    logic [W-1:0] pix;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      localparam int SEL  = tap_sel(m, PX, PY);
      localparam int KIND = SEL / K_SCALE;
      localparam int IDX  = SEL % K_SCALE;
      if (KIND == K_TOP) begin : g_top
        assign cand[m] = top_i[IDX];
      end else if (KIND == K_LEFT) begin : g_left
        assign cand[m] = left_i[IDX];
      end else if (KIND == K_T3) begin : g_t3
        assign cand[m] = tap3_i[IDX];
      end else if (KIND == K_T2) begin : g_t2
        assign cand[m] = tap2_i[IDX];
      end else begin : g_dc
        assign cand[m] = dc_i;
      end
    end

    always_comb begin
      pix = cand[M_DC];
      if (mode_i < MODE_W'(NUM_MODES)) pix = cand[mode_i];
    end
    assign pred_o[p] = pix;
  end
endmodule

// File: rtl/intra4x4_pred.sv
module intra4x4_pred import intra4_pkg::*; #(
  parameter int W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NUM_LEFT*W-1:0]  left_i,
  input  logic [NUM_ABOVE*W-1:0] above_i,
  input  logic [W-1:0]           corner_i,
  input  logic [MODE_W-1:0]      mode_i,
  input  logic [AVAIL_W-1:0]     avail_i,
  output logic [NUM_PIX*W-1:0]   pred_o,
  output logic                   done_o,
  output logic                   err_o
);
  logic [NUM_LEFT-1:0][W-1:0]  cap_left;
  logic [NUM_ABOVE-1:0][W-1:0] cap_above;
  logic [W-1:0]                cap_corner;
  logic [MODE_W-1:0]           cap_mode;
  logic [AVAIL_W-1:0]          cap_avail;
  logic                        cap_vld;

  logic [TAP3_HI:1][W-1:0]     tap3;
  logic [TAP2_HI:1][W-1:0]     tap2;
  logic [W-1:0]                dc_val;
  logic                        bad;
  logic [NUM_PIX-1:0][W-1:0]   pred_c;
  logic [NUM_PIX-1:0][W-1:0]   pred_q;
  logic                        done_q, err_q;

  // capture stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_left   <= '0;
      cap_above  <= '0;
      cap_corner <= '0;
      cap_mode   <= '0;
      cap_avail  <= '0;
      cap_vld    <= 1'b0;
    end else begin
      cap_vld <= start_i;
      if (start_i) begin
        cap_left   <= left_i;
        cap_above  <= above_i;
        cap_corner <= corner_i;
        cap_mode   <= mode_i;
        cap_avail  <= avail_i;
      end
    end
  end

  intra4_edge #(.W(W)) u_edge (
    .left_i      (cap_left),
    .above_i     (cap_above),
    .corner_i    (cap_corner),
    .top_rt_ok_i (cap_avail[AV_TOP_RT]),
    .tap3_o      (tap3),
    .tap2_o      (tap2)
  );

  intra4_dc #(.W(W)) u_dc (
    .left_i    (cap_left),
    .top_i     (cap_above[BLK-1:0]),
    .left_ok_i (cap_avail[AV_LEFT]),
    .top_ok_i  (cap_avail[AV_TOP]),
    .dc_o      (dc_val)
  );

  intra4_legal u_legal (
    .mode_i      (cap_mode),
    .left_ok_i   (cap_avail[AV_LEFT]),
    .top_ok_i    (cap_avail[AV_TOP]),
    .corner_ok_i (cap_avail[AV_CORNER]),
    .bad_o       (bad)
  );

  intra4_map #(.W(W)) u_map (
    .mode_i (cap_mode),
    .left_i (cap_left),
    .top_i  (cap_above[BLK-1:0]),
    .tap3_i (tap3),
    .tap2_i (tap2),
    .dc_i   (dc_val),
    .pred_o (pred_c)
  );

  // result stage; rejected requests leave the tile untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= cap_vld;
      if (cap_vld) begin
        err_q <= bad;
        if (!bad) pred_q <= pred_c;
      end
    end
  end

  assign pred_o = pred_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/intra4x4_pred_chk.sv
module intra4x4_pred_chk import intra4_pkg::*; #(
  parameter int W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [NUM_LEFT*W-1:0]  left_i,
  input logic [NUM_ABOVE*W-1:0] above_i,
  input logic [W-1:0]           corner_i,
  input logic [MODE_W-1:0]      mode_i,
  input logic [AVAIL_W-1:0]     avail_i,
  input logic [NUM_PIX*W-1:0]   pred_o,
  input logic                   done_o,
  input logic                   err_o
);
  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##2 done_o); // R2

  AST_DONE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2)); // R2

  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pred_o) && $stable(err_o))); // R2

  AST_ERR_KEEPS_TILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> $stable(pred_o)); // R3

  AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(mode_i, 2) >= MODE_W'(NUM_MODES))) |-> err_o); // R3

  AST_DC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(mode_i, 2) == MODE_W'(M_DC))) |-> !err_o); // R6

  AST_VERT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && ($past(mode_i, 2) == MODE_W'(M_VERT)))
      |-> (pred_o[W-1:0] == $past(above_i[W-1:0], 2))); // R5
endmodule

bind intra4x4_pred intra4x4_pred_chk #(.W(W)) u_chk (.*);

// File: tb/intra4x4_pred_test.sv
module intra4x4_pred_test;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4*W-1:0]  left_v = '0;
  logic [8*W-1:0]  above_v = '0;
  logic [W-1:0]    corner_v = '0;
  logic [3:0]      mode_v = '0;
  logic [3:0]      avail_v = '0;
  logic [16*W-1:0] pred;
  logic            done, err;

  int total = 0;
  int bad = 0;
  int l[4];
  int u[8];
  int ul;
  int unsigned seed = 32'h1234_5678;
  logic [16*W-1:0] prev_exp = '0;

  always #(CLK_P/2) clk = ~clk;

  intra4x4_pred #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .left_i(left_v), .above_i(above_v), .corner_i(corner_v),
    .mode_i(mode_v), .avail_i(avail_v),
    .pred_o(pred), .done_o(done), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [16*W-1:0] act, input logic [16*W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int f3(int a, int b, int c);
    return (a + 2 * b + c + 2) >> 2;
  endfunction
  function automatic int f2(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic string mode_tag(int md);
    case (md)
      0, 1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5, 6: return "R9";
      7: return "R10";
      8: return "R11";
      default: return "R3";
    endcase
  endfunction

  // reference model from the requirements
  task automatic model(input int md, input logic [3:0] av,
                       output logic [16*W-1:0] ev, output bit is_bad);
    int t[10];
    int s[9];
    int e[16];
    int sm;
    is_bad = 1'b0;
    case (md)
      0, 3, 7: is_bad = !av[1];
      1, 8:    is_bad = !av[0];
      2:       is_bad = 1'b0;
      4, 5, 6: is_bad = !(av[0] && av[1] && av[2]);
      default: is_bad = 1'b1;
    endcase
    for (int i = 0; i < 16; i++) e[i] = 0;
    case (md)
      0: for (int p = 0; p < 16; p++) e[p] = u[p % 4];
      1: for (int p = 0; p < 16; p++) e[p] = l[p / 4];
      2: begin
        sm = 0;
        if (av[0] && av[1]) begin
          for (int k = 0; k < 4; k++) sm += l[k] + u[k];
          sm = (sm + 4) >> 3;
        end else if (av[0]) begin
          for (int k = 0; k < 4; k++) sm += l[k];
          sm = (sm + 2) >> 2;
        end else if (av[1]) begin
          for (int k = 0; k < 4; k++) sm += u[k];
          sm = (sm + 2) >> 2;
        end else sm = 128;
        for (int p = 0; p < 16; p++) e[p] = sm;
      end
      3: begin
        if (av[3]) begin
          for (int i = 0; i < 6; i++) t[i] = f3(u[i], u[i+1], u[i+2]);
          t[6] = (u[6] + 3 * u[7] + 2) >> 2;
        end else begin
          t[0] = f3(u[0], u[1], u[2]);
          t[1] = f3(u[1], u[2], u[3]);
          t[2] = (u[2] + 3 * u[3] + 2) >> 2;
          for (int i = 3; i < 7; i++) t[i] = u[3];
        end
        for (int p = 0; p < 16; p++) e[p] = t[p % 4 + p / 4];
      end
      4: begin
        s[0] = l[3]; s[1] = l[2]; s[2] = l[1]; s[3] = l[0]; s[4] = ul;
        for (int k = 0; k < 4; k++) s[5+k] = u[k];
        for (int i = 0; i < 7; i++) t[i] = f3(s[i], s[i+1], s[i+2]);
        for (int p = 0; p < 16; p++) e[p] = t[3 + p % 4 - p / 4];
      end
      5: begin
        t[0] = f3(l[2], l[1], l[0]); t[1] = f3(l[1], l[0], ul);
        t[2] = f3(l[0], ul, u[0]);   t[3] = f2(ul, u[0]);
        t[4] = f3(ul, u[0], u[1]);   t[5] = f2(u[0], u[1]);
        t[6] = f3(u[0], u[1], u[2]); t[7] = f2(u[1], u[2]);
        t[8] = f3(u[1], u[2], u[3]); t[9] = f2(u[2], u[3]);
        for (int p = 0; p < 16; p++) e[p] = t[3 + 2 * (p % 4) - p / 4];
      end
      6: begin
        t[0] = f3(u[2], u[1], u[0]); t[1] = f3(u[1], u[0], ul);
        t[2] = f3(u[0], ul, l[0]);   t[3] = f2(ul, l[0]);
        t[4] = f3(ul, l[0], l[1]);   t[5] = f2(l[0], l[1]);
        t[6] = f3(l[0], l[1], l[2]); t[7] = f2(l[1], l[2]);
        t[8] = f3(l[1], l[2], l[3]); t[9] = f2(l[2], l[3]);
        for (int p = 0; p < 16; p++) e[p] = t[3 + 2 * (p / 4) - p % 4];
      end
      7: begin
        t[0] = f2(u[0], u[1]); t[1] = f3(u[0], u[1], u[2]);
        t[2] = f2(u[1], u[2]); t[3] = f3(u[1], u[2], u[3]);
        t[4] = f2(u[2], u[3]);
        if (av[3]) begin
          t[5] = f3(u[2], u[3], u[4]); t[6] = f2(u[3], u[4]);
          t[7] = f3(u[3], u[4], u[5]); t[8] = f2(u[4], u[5]);
          t[9] = f3(u[4], u[5], u[6]);
        end else begin
          t[5] = (u[2] + 3 * u[3] + 2) >> 2;
          for (int i = 6; i < 10; i++) t[i] = u[3];
        end
        for (int p = 0; p < 16; p++) e[p] = t[2 * (p % 4) + p / 4];
      end
      8: begin
        t[0] = f2(l[0], l[1]); t[1] = f3(l[0], l[1], l[2]);
        t[2] = f2(l[1], l[2]); t[3] = f3(l[1], l[2], l[3]);
        t[4] = f2(l[2], l[3]); t[5] = (l[2] + 3 * l[3] + 2) >> 2;
        for (int i = 6; i < 10; i++) t[i] = l[3];
        for (int p = 0; p < 16; p++) e[p] = t[p % 4 + 2 * (p / 4)];
      end
      default: ;
    endcase
    if (is_bad) ev = prev_exp;
    else for (int p = 0; p < 16; p++) ev[p*W +: W] = W'(e[p]);
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  task automatic fill(input int pat);
    for (int k = 0; k < 8; k++) begin
      case (pat)
        0: u[k] = 255;
        1: u[k] = 0;
        2: u[k] = (k % 2) ? 255 : 0;
        default: u[k] = rnd();
      endcase
    end
    for (int k = 0; k < 4; k++) begin
      case (pat)
        0: l[k] = 255;
        1: l[k] = 0;
        2: l[k] = (k % 2) ? 0 : 255;
        default: l[k] = rnd();
      endcase
    end
    ul = (pat == 0) ? 255 : (pat == 1) ? 0 : (pat == 2) ? 128 : rnd();
  endtask

  task automatic drive(input int md, input logic [3:0] av);
    for (int k = 0; k < 4; k++) left_v[k*W +: W] = W'(l[k]);
    for (int k = 0; k < 8; k++) above_v[k*W +: W] = W'(u[k]);
    corner_v = W'(ul);
    mode_v = 4'(md);
    avail_v = av;
  endtask

  task automatic run(input int md, input logic [3:0] av, input string tag);
    logic [16*W-1:0] ev;
    bit eb;
    model(md, av, ev, eb);
    @(negedge clk);
    drive(md, av);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2", "done early/pulse too long", 128'(done), 128'(0));
    @(negedge clk);
    check(done == 1'b1, "R2", "done missing", 128'(done), 128'(1));
    check(err == eb, "R3", $sformatf("err mode=%0d av=%b", md, av), 128'(err), 128'(eb));
    check(pred == ev, tag, $sformatf("tile mode=%0d av=%b", md, av), pred, ev);
    prev_exp = ev;
  endtask

  initial begin
    repeat (CLK_P * 150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [16*W-1:0] ea, eb2;
    bit ba, bb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pred == '0 && done == 1'b0 && err == 1'b0, "R1", "reset state",
          {pred[16*W-1:2], done, err}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pred == '0 && done == 1'b0 && err == 1'b0, "R1", "after release",
          {pred[16*W-1:2], done, err}, '0);

    // first request rejected: tile must stay at reset value (R3)
    fill(3);
    run(0, 4'b0000, "R3");

    // R4 rounding: DC with one side, and 2-tap halves
    l[0] = 0; l[1] = 1; l[2] = 2; l[3] = 3;
    run(8, 4'b0001, "R4");
    u[0] = 2; u[1] = 0; u[2] = 0; u[3] = 0;
    run(2, 4'b0010, "R4");

    // sweep all codes, masks and patterns
    for (int pat = 0; pat < 6; pat++) begin
      for (int mi = 0; mi < 11; mi++) begin
        for (int av = 0; av < 16; av++) begin
          int md;
          md = (mi == 10) ? 15 : mi;
          fill(pat);
          run(md, 4'(av), mode_tag(md));
        end
      end
    end

    // R12 back-to-back starts
    fill(4);
    model(4, 4'b0111, ea, ba);
    @(negedge clk);
    drive(4, 4'b0111);
    start = 1'b1;
    prev_exp = ea;
    fill(5);
    model(7, 4'b1010, eb2, bb);
    @(negedge clk);
    drive(7, 4'b1010);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && pred == ea && err == ba, "R12", "first of pair", pred, ea);
    @(negedge clk);
    check(done == 1'b1 && pred == eb2 && err == bb, "R12", "second of pair", pred, eb2);
    @(negedge clk);
    check(done == 1'b0, "R12", "pair pulse end", 128'(done), 128'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule